// File: doc/BRIEF.md
# Endpoint Handshake Control Register

This block is the control and status register of a single USB device endpoint, together with the logic that picks the handshake the device answers each token with. It holds a sticky correct-transfer flag, a transmit and a receive data-toggle bit, and a two-bit status field for each direction. Software reads the whole register at any time and writes it over a simple one-cycle write strobe.

A packet engine outside the block sends single-cycle event pulses. There is one for a received SETUP PID, one for a host ACK after transmitted data, one for an error-free data packet (with the DATA0/DATA1 value it carried), and one for a completed transfer. The block updates the toggles and status from these pulses. After every correct transfer it drops both status fields back to NAK, so software has to re-arm the endpoint before the next transfer is accepted. For each token the engine presents, the block returns the handshake to send, in the same cycle.

A USB bus reset and a reset forced by software both clear the toggles and the status fields. They leave the correct-transfer flag alone.

Top module: `usb_ep_hs_reg`

## Requirements
- R1: `reg_rdata` packs the state as bit 7 correct-transfer flag, bit 6 transmit toggle, bits 5:4 transmit status, bit 3 constant 0, bit 2 receive toggle, bits 1:0 receive status. It reads 00h after `rst_n` is asserted.
- R2: A correct transfer sets the flag on the next edge. The flag stays set until a software write with bit 7 = 0. A write with bit 7 = 1 leaves it unchanged. A hardware set wins over a software clear in the same cycle.
- R3: A correct transfer forces both status fields to NAK (10) on the next edge. This overrides a software write in the same cycle.
- R4: `ev_setup` sets the transmit toggle to 1 and clears the receive toggle to 0 on the next edge. This wins over any other toggle event or write in that cycle.
- R5: The transmit toggle inverts on `ev_host_ack` and on no other hardware event.
- R6: On `ev_data_ok`, the receive toggle inverts only when `ev_data_pid` equals its current value. On a mismatch it is unchanged, and a simultaneous `ev_xfer_done` does not count as a correct transfer: the flag is not set and the status fields are not forced to NAK.
- R7: When no hardware event touches a field, a software write loads both toggles (bits 6 and 2) and both status fields (bits 5:4, 1:0) from `reg_wdata`.
- R8: `usb_bus_rst` or `force_rst` clears both toggles and both status fields on the next edge, above every other source. The correct-transfer flag is not affected.
- R9: An IN token (`tok_kind` 00) gets handshake code 00 (none) when the transmit status is DISABLED (00) or VALID (11). It gets STALL (11) for status STALL (01) and NAK (10) for status NAK (10).
- R10: An OUT token (`tok_kind` 01) gets none for receive status DISABLED, STALL for STALL, NAK for NAK, and ACK (01) for VALID, whatever the packet toggle is.
- R11: A SETUP token (`tok_kind` 10) gets ACK unless the receive status is DISABLED, which gives none. Kind 11 and `tok_valid` = 0 give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_bus_rst | input | 1 | USB bus reset seen on the bus |
| force_rst | input | 1 | Bus reset forced by software |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ev_setup | input | 1 | SETUP PID received |
| ev_host_ack | input | 1 | Host ACK received after transmitted data |
| ev_data_ok | input | 1 | Data packet received without error |
| ev_data_pid | input | 1 | Data PID of that packet, 0 = DATA0, 1 = DATA1 |
| ev_xfer_done | input | 1 | Transfer completed on this endpoint |
| tok_valid | input | 1 | Token present |
| tok_kind | input | 2 | 00 IN, 01 OUT, 10 SETUP, 11 unused |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |

## Verification
The handshake decision is tried with every token kind against all four codes of the field that governs it. This shows which direction's status each kind looks at, and that VALID on IN gives no handshake where VALID on OUT gives ACK. The toggle logic is driven with matching and mismatching data PIDs, with SETUP and ACK pulses on their own and colliding with each other and with software writes. These patterns tell the event priorities apart and show a mismatched packet being kept out of the correct-transfer path. Software writes of 0 and of 1 to the flag, alone and in the same cycle as a completed transfer, separate the sticky-flag rule from the hardware-wins rule. Bus and forced resets applied over pending events show that they override everything except the flag.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int REG_W   = 8;
  localparam int STAT_W  = 2;
  localparam int FLAG_B  = 7;
  localparam int TXTOG_B = 6;
  localparam int TXST_LO = 4;
  localparam int RXTOG_B = 2;
  localparam int RXST_LO = 0;

  typedef enum logic [STAT_W-1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } ep_stat_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    TK_IN    = 2'b00,
    TK_OUT   = 2'b01,
    TK_SETUP = 2'b10,
    TK_RSVD  = 2'b11
  } tok_e;

  // Handshake implied by a single status field for a data token.
  function automatic hs_e stat_to_hs(input ep_stat_e st, input logic valid_acks);
    case (st)
      ST_STALL: stat_to_hs = HS_STALL;
      ST_NAK:   stat_to_hs = HS_NAK;
      ST_VALID: stat_to_hs = valid_acks ? HS_ACK : HS_NONE;
      default:  stat_to_hs = HS_NONE;
    endcase
  endfunction

  function automatic hs_e decide_hs(input logic present, input tok_e kind,
                                    input ep_stat_e txs, input ep_stat_e rxs);
    if (!present) begin
      decide_hs = HS_NONE;
    end else begin
      case (kind)
        TK_IN:    decide_hs = stat_to_hs(txs, 1'b0);
        TK_OUT:   decide_hs = stat_to_hs(rxs, 1'b1);
        TK_SETUP: decide_hs = (rxs == ST_DIS) ? HS_NONE : HS_ACK;
        default:  decide_hs = HS_NONE;
      endcase
    end
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(input logic flag, input logic txt,
                                                input ep_stat_e txs, input logic rxt,
                                                input ep_stat_e rxs);
    logic [REG_W-1:0] v;
    v = '0;
    v[FLAG_B]                   = flag;
    v[TXTOG_B]                  = txt;
    v[TXST_LO +: STAT_W]        = txs;
    v[RXTOG_B]                  = rxt;
    v[RXST_LO +: STAT_W]        = rxs;
    return v;
  endfunction
endpackage

// File: rtl/ep_ctr_flag.sv
module ep_ctr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic sw_wr_i,
  input  logic sw_bit_i,
  output logic flag_o
);
  logic sw_clear;
  assign sw_clear = sw_wr_i & ~sw_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (set_i)    flag_o <= 1'b1;
    else if (sw_clear) flag_o <= 1'b0;
  end

  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(sw_wr_i && !sw_bit_i)) |=> flag_o);
  a_r2_only_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/ep_toggles.sv
module ep_toggles (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic setup_i,
  input  logic host_ack_i,
  input  logic data_ok_i,
  input  logic data_pid_i,
  input  logic sw_wr_i,
  input  logic sw_tx_i,
  input  logic sw_rx_i,
  output logic tx_tog_o,
  output logic rx_tog_o,
  output logic pid_match_o
);
  logic tx_nxt, rx_nxt;

  assign pid_match_o = (data_pid_i == rx_tog_o);

  always_comb begin
    tx_nxt = tx_tog_o;
    if (clr_i)           tx_nxt = 1'b0;
    else if (setup_i)    tx_nxt = 1'b1;
    else if (host_ack_i) tx_nxt = ~tx_tog_o;
    else if (sw_wr_i)    tx_nxt = sw_tx_i;
  end

  always_comb begin
    rx_nxt = rx_tog_o;
    if (clr_i)                          rx_nxt = 1'b0;
    else if (setup_i)                   rx_nxt = 1'b0;
    else if (data_ok_i && pid_match_o)  rx_nxt = ~rx_tog_o;
    else if (data_ok_i)                 rx_nxt = rx_tog_o;
    else if (sw_wr_i)                   rx_nxt = sw_rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_tog_o <= 1'b0;
      rx_tog_o <= 1'b0;
    end else begin
      tx_tog_o <= tx_nxt;
      rx_tog_o <= rx_nxt;
    end
  end

  a_r4_setup_tog: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_i && !clr_i) |=> (tx_tog_o && !rx_tog_o));
  a_r5_ack_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack_i && !setup_i && !clr_i) |=> (tx_tog_o != $past(tx_tog_o)));
  a_r6_mismatch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok_i && !pid_match_o && !setup_i && !clr_i) |=> $stable(rx_tog_o));
  a_r8_clear_tog: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!tx_tog_o && !rx_tog_o));
endmodule

// File: rtl/ep_status_fields.sv
module ep_status_fields
  import ep_hs_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       nak_i,
  input  logic                       sw_wr_i,
  input  logic [NCH-1:0][STAT_W-1:0] sw_val_i,
  output logic [NCH-1:0][STAT_W-1:0] stat_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAT_W-1:0] nxt;
    always_comb begin
      nxt = stat_o[c];
      if (clr_i)        nxt = ST_DIS;
      else if (nak_i)   nxt = ST_NAK;
      else if (sw_wr_i) nxt = sw_val_i[c];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o[c] <= ST_DIS;
      else        stat_o[c] <= nxt;
    end

    a_r3_auto_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (nak_i && !clr_i) |=> (stat_o[c] == ST_NAK));
    a_r8_clear_stat: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (stat_o[c] == ST_DIS));
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !nak_i && !sw_wr_i) |=> $stable(stat_o[c]));
  end
endmodule

// File: rtl/ep_hs_decode.sv
module ep_hs_decode
  import ep_hs_pkg::*;
(
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic [STAT_W-1:0] tx_stat_i,
  input  logic [STAT_W-1:0] rx_stat_i,
  output logic [1:0]        hs_o
);
  always_comb begin
    hs_o = decide_hs(tok_valid_i, tok_e'(tok_kind_i),
                     ep_stat_e'(tx_stat_i), ep_stat_e'(rx_stat_i));
  end

  always_comb begin
    if (tok_valid_i && tok_kind_i == TK_IN)
      a_r9_in_never_acks: assert (hs_o != HS_ACK);
    if (tok_valid_i && tok_kind_i == TK_OUT && hs_o == HS_ACK)
      a_r10_ack_needs_valid: assert (rx_stat_i == ST_VALID);
    if (!tok_valid_i)
      a_r11_idle_silent: assert (hs_o == HS_NONE);
  end
endmodule

// File: rtl/usb_ep_hs_reg.sv
module usb_ep_hs_reg
  import ep_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_bus_rst,
  input  logic             force_rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_setup,
  input  logic             ev_host_ack,
  input  logic             ev_data_ok,
  input  logic             ev_data_pid,
  input  logic             ev_xfer_done,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  output logic [1:0]       hs_code
);
  logic                     field_clr;
  logic                     pid_match;
  logic                     bad_seq;
  logic                     xfer_ok;
  logic                     flag_q;
  logic                     tx_tog, rx_tog;
  logic [1:0][STAT_W-1:0]   stat_q;
  logic [1:0][STAT_W-1:0]   stat_wr;

  assign field_clr = usb_bus_rst | force_rst;
  assign bad_seq   = ev_data_ok & ~pid_match;
  assign xfer_ok   = ev_xfer_done & ~bad_seq;
  assign stat_wr[0] = reg_wdata[RXST_LO +: STAT_W];
  assign stat_wr[1] = reg_wdata[TXST_LO +: STAT_W];

  ep_ctr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(xfer_ok),
    .sw_wr_i(reg_wr), .sw_bit_i(reg_wdata[FLAG_B]), .flag_o(flag_q)
  );

  ep_toggles u_tog (
    .clk(clk), .rst_n(rst_n), .clr_i(field_clr), .setup_i(ev_setup),
    .host_ack_i(ev_host_ack), .data_ok_i(ev_data_ok), .data_pid_i(ev_data_pid),
    .sw_wr_i(reg_wr), .sw_tx_i(reg_wdata[TXTOG_B]), .sw_rx_i(reg_wdata[RXTOG_B]),
    .tx_tog_o(tx_tog), .rx_tog_o(rx_tog), .pid_match_o(pid_match)
  );

  ep_status_fields #(.NCH(2)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr_i(field_clr), .nak_i(xfer_ok),
    .sw_wr_i(reg_wr), .sw_val_i(stat_wr), .stat_o(stat_q)
  );

  ep_hs_decode u_hs (
    .tok_valid_i(tok_valid), .tok_kind_i(tok_kind),
    .tx_stat_i(stat_q[1]), .rx_stat_i(stat_q[0]), .hs_o(hs_code)
  );

  assign reg_rdata = pack_reg(flag_q, tx_tog, ep_stat_e'(stat_q[1]),
                              rx_tog, ep_stat_e'(stat_q[0]));

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[3] == 1'b0));
  a_r6_bad_seq_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_seq && !flag_q && !field_clr && !reg_wr) |=> !reg_rdata[FLAG_B]);
  a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_done && !ev_data_ok) |=> reg_rdata[FLAG_B]);
endmodule

// File: tb/sim_usb_ep_hs_reg.sv
module sim_usb_ep_hs_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usb_bus_rst = 0, force_rst = 0, reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ev_setup = 0, ev_host_ack = 0, ev_data_ok = 0, ev_data_pid = 0, ev_xfer_done = 0;
  logic tok_valid = 0;
  logic [1:0] tok_kind = '0;
  logic [1:0] hs_code;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_flag = 0, m_txt = 0, m_rxt = 0, m_txs = 0, m_rxs = 0;

  always #2 clk = ~clk;

  usb_ep_hs_reg u0 (
    .clk(clk), .rst_n(rst_n), .usb_bus_rst(usb_bus_rst), .force_rst(force_rst),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_setup(ev_setup), .ev_host_ack(ev_host_ack), .ev_data_ok(ev_data_ok),
    .ev_data_pid(ev_data_pid), .ev_xfer_done(ev_xfer_done),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .hs_code(hs_code)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_txt = 0; m_rxt = 0; m_txs = 0; m_rxs = 0;
    end else begin
      int good, n_txt, n_rxt, n_txs, n_rxs;
      good = ev_xfer_done && !(ev_data_ok && (ev_data_pid != m_rxt));
      n_txt = m_txt; n_rxt = m_rxt; n_txs = m_txs; n_rxs = m_rxs;
      if (reg_wr) begin
        n_txt = reg_wdata[6]; n_rxt = reg_wdata[2];
        n_txs = reg_wdata[5:4]; n_rxs = reg_wdata[1:0];
      end
      if (ev_data_ok) n_rxt = (ev_data_pid == m_rxt) ? 1 - m_rxt : m_rxt;
      if (ev_host_ack) n_txt = 1 - m_txt;
      if (ev_setup) begin n_txt = 1; n_rxt = 0; end
      if (good) begin n_txs = 2; n_rxs = 2; end
      if (usb_bus_rst || force_rst) begin n_txt = 0; n_rxt = 0; n_txs = 0; n_rxs = 0; end
      if (good) m_flag = 1;
      else if (reg_wr && !reg_wdata[7]) m_flag = 0;
      m_txt = n_txt; m_rxt = n_rxt; m_txs = n_txs; m_rxs = n_rxs;
    end
  end

  function automatic int model_hs();
    if (!tok_valid) return 0;
    case (tok_kind)
      2'd0: return (m_txs == 1) ? 3 : (m_txs == 2) ? 2 : 0;
      2'd1: return (m_rxs == 0) ? 0 : (m_rxs == 1) ? 3 : (m_rxs == 2) ? 2 : 1;
      2'd2: return (m_rxs == 0) ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic int model_reg();
    return m_flag * 128 + m_txt * 64 + m_txs * 16 + m_rxt * 4 + m_rxs;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    usb_bus_rst = 0; force_rst = 0; reg_wr = 0; reg_wdata = '0;
    ev_setup = 0; ev_host_ack = 0; ev_data_ok = 0; ev_data_pid = 0;
    ev_xfer_done = 0; tok_valid = 0; tok_kind = '0;
  endtask

  // inputs already driven after a negedge; check handshake, clock, check register
  task automatic step(input string req);
    #1 chk(req, "hs_code", int'(hs_code), model_hs());
    @(posedge clk);
    @(negedge clk);
    chk(req, "reg_rdata", int'(reg_rdata), model_reg());
    clear_in();
  endtask

  task automatic wr(input logic [7:0] v, input string req);
    reg_wr = 1; reg_wdata = v; step(req);
  endtask

  task automatic tok_sweep(input string req, input logic [1:0] kind);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] v;
      v = {1'b0, 1'b0, s[1:0], 1'b0, 1'b0, s[1:0]};
      wr(v, req);
      tok_valid = 1; tok_kind = kind; step(req);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    repeat (2) @(negedge clk);
    chk("R1", "reset value", int'(reg_rdata), 0);
    rst_n = 1;
    @(negedge clk);
    step("R1");
    // R7: software loads toggles and status, bit 3 ignored
    wr(8'h7F, "R7");
    chk("R1", "bit3 zero", int'(reg_rdata[3]), 0);
    wr(8'h00, "R7");
    wr(8'h66, "R7");
    // R9 R10 R11 handshake sweeps
    tok_sweep("R9", 2'd0);
    tok_sweep("R10", 2'd1);
    tok_sweep("R11", 2'd2);
    tok_sweep("R11", 2'd3);
    // R4 setup
    wr(8'h04, "R7");
    ev_setup = 1; step("R4");
    ev_setup = 1; ev_host_ack = 1; ev_data_ok = 1; ev_data_pid = 0; step("R4");
    ev_setup = 1; reg_wr = 1; reg_wdata = 8'h04; step("R4");
    // R5 host ack flips
    ev_host_ack = 1; step("R5");
    ev_host_ack = 1; step("R5");
    ev_host_ack = 1; reg_wr = 1; reg_wdata = 8'h40; step("R5");
    ev_data_ok = 1; ev_data_pid = 0; step("R5");
    // R6 rx toggle match / mismatch
    wr(8'h33, "R7");
    ev_data_ok = 1; ev_data_pid = 0; step("R6");
    ev_data_ok = 1; ev_data_pid = 1; step("R6");
    ev_data_ok = 1; ev_data_pid = 1; ev_xfer_done = 1; step("R6");
    tok_valid = 1; tok_kind = 2'd1; ev_data_ok = 1; ev_data_pid = 0; ev_xfer_done = 1; step("R6");
    // R3 / R2 correct transfer
    wr(8'h33, "R7");
    ev_xfer_done = 1; step("R3");
    wr(8'hB3, "R2");
    wr(8'h33, "R2");
    ev_xfer_done = 1; reg_wr = 1; reg_wdata = 8'h33; step("R2");
    wr(8'h80, "R2");
    wr(8'h00, "R2");
    ev_xfer_done = 1; reg_wr = 1; reg_wdata = 8'h7F; step("R3");
    // R8 resets
    wr(8'hF7, "R7");
    usb_bus_rst = 1; ev_setup = 1; ev_xfer_done = 1; step("R8");
    wr(8'h77, "R7");
    force_rst = 1; reg_wr = 1; reg_wdata = 8'h77; ev_host_ack = 1; step("R8");
    wr(8'h00, "R2");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int r;
      r = (i * 37 + 11) % 97;
      ev_setup = (r % 13) == 0;
      ev_host_ack = (r % 3) == 1;
      ev_data_ok = (r % 4) == 2;
      ev_data_pid = r[4];
      ev_xfer_done = (r % 5) == 3;
      reg_wr = (r % 6) == 0;
      reg_wdata = 8'(r * 29 + i);
      usb_bus_rst = (r % 31) == 7;
      tok_valid = r[1];
      tok_kind = 2'(r >> 2);
      step("R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule